// File: doc/BRIEF.md
# Pulse-and-Verify Memory Programming Sequencer

This block writes the contents of a source buffer into a byte-wide one-time or erasable non-volatile memory. Software or a host controller provides a start strobe, a base address and a byte count. The sequencer then works through each address. It fetches the wanted byte from the source interface and raises the programming-voltage request. It selects the programming supply level. It then applies fixed-width program pulses, reading the cell back after each one, until the byte matches or the retry cap is used up.

Once every byte in the range is programmed, the block re-reads the whole range twice against the source: first with the supply select at a high setting, then at a low setting. A one-cycle `done` strobe ends every run. After it, `pass`, `fail_addr` and `fail_phase` stay held until the next start. Voltage generation and the memory array are outside the block. It only drives the requests and the bus lines.

Top module: `pv_prog_seq`

## Requirements
- R1: Out of reset and while idle, `mem_ce_n` and `mem_oe_n` are high, `vpp_req` is low, `vsel` is 2'b00 (nominal) and `done` is low.
- R2: Each program pulse drives `mem_ce_n` low with `mem_oe_n` high for exactly `PULSE_CYC` clock cycles. During the pulse, `mem_wdata` carries the target byte from the source.
- R3: After each pulse the cell is read back with `mem_oe_n` low and `mem_ce_n` high. A match moves on to the next address, and the pulse count restarts at zero there.
- R4: A byte that first matches after N pulses receives exactly N pulses; no extra pulse follows a good verify.
- R5: If `MAX_PULSES` (default 25) pulses leave a byte unmatched, the run ends with `pass` low, `fail_phase` = 2'b01 and `fail_addr` = that address.
- R6: Throughout the programming phase `vpp_req` is high and `vsel` is 2'b01 (program level); `mem_ce_n` and `mem_oe_n` are never low together while `vpp_req` is high.
- R7: An address whose source byte is all ones (8'hFF) receives no pulse.
- R8: After programming, every byte in the range is read with both enables low, first at `vsel` = 2'b10 (high) and then at `vsel` = 2'b11 (low). A mismatch ends the run with `fail_phase` 2'b10 or 2'b11 respectively and `fail_addr` set to the address.
- R9: `done` is high for exactly one cycle per run. `pass` is high afterwards only if all phases succeeded, and a zero length finishes at once with `pass` high and no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled while idle) |
| base_addr | input | AW | First address of the range |
| length | input | AW+1 | Number of bytes to program |
| src_addr | output | AW | Address presented to the source buffer |
| src_data | input | DW | Source byte at `src_addr` (combinational read) |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Byte driven onto the memory data pins |
| mem_wdata_oe | output | 1 | Enable for the data pin drivers |
| mem_rdata | input | DW | Byte read from the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| vpp_req | output | 1 | Request for the programming voltage |
| vsel | output | 2 | Supply select: 00 nominal, 01 program, 10 high check, 11 low check |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | Run result, held until next start |
| fail_addr | output | AW | Address where a failure occurred |
| fail_phase | output | 2 | 00 none, 01 program, 10 high check, 11 low check |

## Verification
The embedded properties assume three things about the inputs. `start` is only pulsed while the block is idle. The source buffer stays unchanged for the whole run. The memory returns read data within the settle delay after an enable change. The bench respects all three. Its source array is filled once and never written. Its memory model answers combinationally from a cell array that changes only when a pulse ends. Each run waits for `done` before the next `start` is driven. Failure cases are injected through the model, either as a cell needing more pulses than the cap or as a bit flipped only under one check supply level, so the sequencer never sees an input outside these assumptions.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_SETUP,
      S_PULSE,
      S_RECOVER,
      S_VERIFY,
      S_NEXT,
      S_CHK_HI,
      S_CHK_LO,
      S_DONE,
      S_FAIL
   } seq_state_t;

   // supply select encodings
   localparam logic [1:0] VS_NOM  = 2'b00;
   localparam logic [1:0] VS_PROG = 2'b01;
   localparam logic [1:0] VS_HI   = 2'b10;
   localparam logic [1:0] VS_LO   = 2'b11;

   // failure phase encodings
   localparam logic [1:0] PH_NONE = 2'b00;
   localparam logic [1:0] PH_PROG = 2'b01;
   localparam logic [1:0] PH_HI   = 2'b10;
   localparam logic [1:0] PH_LO   = 2'b11;

endpackage

// File: rtl/seq_timer.sv
// Down-counter shared by pulse and settle intervals; expired while at zero.
module seq_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   // R2
   tmr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pulse_tally.sv
// Counts program pulses applied to the current byte.
module pulse_tally #(
   parameter int MAX_PULSES = 25,
   localparam int CW = $clog2(MAX_PULSES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic incr,
   output logic at_cap
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clear)
         cnt_q <= '0;
      else if (incr)
         cnt_q <= cnt_q + 1'b1;
   end

   assign at_cap = (cnt_q == CW'(MAX_PULSES));

   // R5
   tally_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      at_cap |-> !incr);
endmodule

// File: rtl/addr_walker.sv
// Walks an address range; last marks the final byte.
module addr_walker #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic [AW:0]   len,
   input  logic          step,
   output logic [AW-1:0] addr,
   output logic          last
);
   logic [AW:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr  <= '0;
         rem_q <= '0;
      end else if (load) begin
         addr  <= base;
         rem_q <= len;
      end else if (step) begin
         addr  <= addr + 1'b1;
         rem_q <= rem_q - 1'b1;
      end
   end

   assign last = (rem_q == (AW+1)'(1));

   // R8
   walk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (rem_q > (AW+1)'(1)));
endmodule

// File: rtl/pv_prog_seq.sv
module pv_prog_seq
   import pgm_pkg::*;
#(
   parameter int AW          = 8,
   parameter int DW          = 8,
   parameter int PULSE_CYC   = 20000,  // 100 us at a 200 MHz clock
   parameter int SETTLE_CYC  = 3,
   parameter int MAX_PULSES  = 25,
   parameter bit SKIP_ERASED = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] base_addr,
   input  logic [AW:0]   length,
   output logic [AW-1:0] src_addr,
   input  logic [DW-1:0] src_data,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_wdata_oe,
   input  logic [DW-1:0] mem_rdata,
   output logic          mem_ce_n,
   output logic          mem_oe_n,
   output logic          vpp_req,
   output logic [1:0]    vsel,
   output logic          done,
   output logic          pass,
   output logic [AW-1:0] fail_addr,
   output logic [1:0]    fail_phase
);
   localparam int TMAX = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
   localparam int TW   = $clog2(TMAX + 1);

   generate
      if (PULSE_CYC < 1)  begin : g_bad_pulse  $error("PULSE_CYC must be >= 1");  end
      if (SETTLE_CYC < 1) begin : g_bad_settle $error("SETTLE_CYC must be >= 1"); end
      if (MAX_PULSES < 1) begin : g_bad_max    $error("MAX_PULSES must be >= 1"); end
      if (AW < 1 || DW < 1) begin : g_bad_w    $error("AW and DW must be >= 1");  end
   endgenerate

   seq_state_t state_q, state_n;
   logic [DW-1:0] target_q;
   logic [AW-1:0] base_q;
   logic [AW:0]   len_q;
   logic          pass_q;
   logic [AW-1:0] faddr_q;
   logic [1:0]    phase_q;

   logic          tmr_load, tmr_exp;
   logic [TW-1:0] tmr_val;
   logic          walk_load, walk_step, walk_last;
   logic [AW-1:0] walk_base, cur_addr;
   logic [AW:0]   walk_len;
   logic          tally_clr, tally_inc, tally_cap;
   logic          src_erased;
   logic          chk_miss;

   generate
      if (SKIP_ERASED) begin : g_skip
         assign src_erased = &src_data;
      end else begin : g_noskip
         assign src_erased = 1'b0;
      end
   endgenerate

   assign chk_miss  = (mem_rdata != src_data);
   assign walk_base = (state_q == S_IDLE) ? base_addr : base_q;
   assign walk_len  = (state_q == S_IDLE) ? length    : len_q;

   always_comb begin
      state_n   = state_q;
      walk_load = 1'b0;
      walk_step = 1'b0;
      tally_clr = 1'b0;
      tally_inc = 1'b0;
      unique case (state_q)
         S_IDLE: begin
            tally_clr = 1'b1;
            if (start) begin
               walk_load = 1'b1;
               state_n   = (length == '0) ? S_DONE : S_SETUP;
            end
         end
         S_SETUP: if (tmr_exp) begin
            if (src_erased) state_n = S_NEXT;
            else begin
               state_n   = S_PULSE;
               tally_inc = 1'b1;
            end
         end
         S_PULSE:   if (tmr_exp) state_n = S_RECOVER;
         S_RECOVER: if (tmr_exp) state_n = S_VERIFY;
         S_VERIFY: if (tmr_exp) begin
            if (mem_rdata == target_q) state_n = S_NEXT;
            else if (tally_cap)        state_n = S_FAIL;
            else begin
               state_n   = S_PULSE;
               tally_inc = 1'b1;
            end
         end
         S_NEXT: begin
            tally_clr = 1'b1;
            if (walk_last) begin
               walk_load = 1'b1;
               state_n   = S_CHK_HI;
            end else begin
               walk_step = 1'b1;
               state_n   = S_SETUP;
            end
         end
         S_CHK_HI: if (tmr_exp) begin
            if (chk_miss) state_n = S_FAIL;
            else if (walk_last) begin
               walk_load = 1'b1;
               state_n   = S_CHK_LO;
            end else walk_step = 1'b1;
         end
         S_CHK_LO: if (tmr_exp) begin
            if (chk_miss)       state_n = S_FAIL;
            else if (walk_last) state_n = S_DONE;
            else                walk_step = 1'b1;
         end
         S_DONE:  state_n = S_IDLE;
         S_FAIL:  state_n = S_IDLE;
         default: state_n = S_IDLE;
      endcase
   end

   assign tmr_load = (state_n != state_q) || walk_step;
   assign tmr_val  = (state_n == S_PULSE) ? TW'(PULSE_CYC - 1) : TW'(SETTLE_CYC - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         target_q <= '1;
         base_q   <= '0;
         len_q    <= '0;
         pass_q   <= 1'b0;
         faddr_q  <= '0;
         phase_q  <= PH_NONE;
      end else begin
         state_q <= state_n;
         if (state_q == S_IDLE && start) begin
            base_q  <= base_addr;
            len_q   <= length;
            pass_q  <= 1'b0;
            faddr_q <= '0;
            phase_q <= PH_NONE;
         end
         if (state_q == S_SETUP && tmr_exp)
            target_q <= src_data;
         if (state_n == S_DONE)
            pass_q <= 1'b1;
         if (state_n == S_FAIL) begin
            faddr_q <= cur_addr;
            phase_q <= (state_q == S_VERIFY) ? PH_PROG :
                       (state_q == S_CHK_HI) ? PH_HI : PH_LO;
         end
      end
   end

   seq_timer #(.TW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
   );

   pulse_tally #(.MAX_PULSES(MAX_PULSES)) u_tally (
      .clk(clk), .rst_n(rst_n), .clear(tally_clr), .incr(tally_inc), .at_cap(tally_cap)
   );

   addr_walker #(.AW(AW)) u_walk (
      .clk(clk), .rst_n(rst_n), .load(walk_load), .base(walk_base), .len(walk_len),
      .step(walk_step), .addr(cur_addr), .last(walk_last)
   );

   logic in_prog, in_chk;
   assign in_prog = (state_q == S_SETUP) || (state_q == S_PULSE) || (state_q == S_RECOVER)
                 || (state_q == S_VERIFY) || (state_q == S_NEXT);
   assign in_chk  = (state_q == S_CHK_HI) || (state_q == S_CHK_LO);

   assign src_addr     = cur_addr;
   assign mem_addr     = cur_addr;
   assign mem_wdata    = target_q;
   assign mem_wdata_oe = (state_q == S_PULSE);
   assign mem_ce_n     = !((state_q == S_PULSE) || in_chk);
   assign mem_oe_n     = !((state_q == S_VERIFY) || in_chk);
   assign vpp_req      = in_prog;
   assign vsel         = in_prog ? VS_PROG :
                         (state_q == S_CHK_HI) ? VS_HI :
                         (state_q == S_CHK_LO) ? VS_LO : VS_NOM;
   assign done         = (state_q == S_DONE) || (state_q == S_FAIL);
   assign pass         = pass_q;
   assign fail_addr    = faddr_q;
   assign fail_phase   = phase_q;

   // R6
   prog_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vpp_req |-> (mem_ce_n || mem_oe_n));
   // R6
   prog_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vpp_req |-> (vsel == VS_PROG));
   // R3
   verify_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vpp_req && !mem_oe_n) |-> (mem_ce_n && !mem_wdata_oe));
   // R7
   no_erased_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SKIP_ERASED && !mem_ce_n && vpp_req) |-> !(&mem_wdata));
   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8
   lo_after_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vsel == VS_LO && $past(vsel) != VS_LO) |-> ($past(vsel) == VS_HI));
endmodule

// File: tb/sim_pv_prog_seq.sv
`timescale 1ns/1ps
module sim_pv_prog_seq;
   localparam int AW = 6;
   localparam int DW = 8;
   localparam int PCYC = 8;
   localparam int NMEM = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] base_addr = '0;
   logic [AW:0]   length = '0;
   logic [AW-1:0] src_addr, mem_addr, fail_addr;
   logic [DW-1:0] src_data, mem_wdata, mem_rdata;
   logic          mem_wdata_oe, mem_ce_n, mem_oe_n, vpp_req, done, pass;
   logic [1:0]    vsel, fail_phase;

   always #2.5 clk = ~clk;

   pv_prog_seq #(.AW(AW), .DW(DW), .PULSE_CYC(PCYC), .SETTLE_CYC(2), .MAX_PULSES(25)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .length(length),
      .src_addr(src_addr), .src_data(src_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_wdata_oe(mem_wdata_oe), .mem_rdata(mem_rdata), .mem_ce_n(mem_ce_n),
      .mem_oe_n(mem_oe_n), .vpp_req(vpp_req), .vsel(vsel), .done(done), .pass(pass),
      .fail_addr(fail_addr), .fail_phase(fail_phase)
   );

   // ---------------- source buffer and memory model ----------------
   logic [7:0] src_mem [NMEM];
   logic [7:0] cells   [NMEM];
   int         need    [NMEM];
   int         pulses  [NMEM];
   int         weak_addr = -1;
   logic [1:0] weak_lvl = 2'b00;

   function automatic logic [7:0] src_val(int a);
      return (a % 5 == 2) ? 8'hFF : 8'(a * 37 + 5);
   endfunction

   initial for (int a = 0; a < NMEM; a++) src_mem[a] = src_val(a);
   assign src_data = src_mem[src_addr];

   always_comb begin
      mem_rdata = 8'hFF;
      if (!mem_oe_n) begin
         mem_rdata = cells[mem_addr];
         if (int'(mem_addr) == weak_addr && vsel == weak_lvl) mem_rdata = mem_rdata ^ 8'h01;
      end
   end

   // monitor flags
   int   cur_w = 0;
   logic prev_low = 1'b0;
   logic [7:0] pdata = 8'h00;
   int   bad_width = 0, bad_data = 0, bad_level = 0, bad_both = 0;
   logic hi_seen = 1'b0, lo_before_hi = 1'b0;
   int   done_cnt = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (done) done_cnt++;
         if (vpp_req && vsel != 2'b01) bad_level++;
         if (vpp_req && !mem_ce_n && !mem_oe_n) bad_both++;
         if (vsel == 2'b10) hi_seen = 1'b1;
         if (vsel == 2'b11 && !hi_seen) lo_before_hi = 1'b1;
         if (!mem_ce_n && vpp_req) begin
            cur_w++;
            pdata = mem_wdata;
            if (!(mem_wdata_oe && mem_oe_n) || mem_wdata != src_mem[mem_addr]) bad_data++;
            prev_low = 1'b1;
         end else if (prev_low) begin
            prev_low = 1'b0;
            if (cur_w != PCYC) bad_width++;
            cur_w = 0;
            pulses[mem_addr]++;
            need[mem_addr]--;
            if (need[mem_addr] == 0) cells[mem_addr] = cells[mem_addr] & pdata;
         end
      end
   end

   // ---------------- bookkeeping ----------------
   int n_tests = 0, n_fail = 0;
   bit finished = 1'b0;

   task automatic check(bit ok, string req, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
   end

   // ---------------- vector table ----------------
   typedef struct packed {
      logic [5:0] base;
      logic [6:0] len;
      logic [2:0] mode;    // 0 normal,1 over cap,2 weak high,3 weak low,4 exactly cap
      logic [5:0] sp;
      logic       exp_pass;
      logic [1:0] exp_phase;
      logic [5:0] exp_faddr;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{6'd0,  7'd6, 3'd0, 6'd0,  1'b1, 2'b00, 6'd0},
      '{6'd10, 7'd5, 3'd0, 6'd0,  1'b1, 2'b00, 6'd0},
      '{6'd20, 7'd4, 3'd4, 6'd21, 1'b1, 2'b00, 6'd0},
      '{6'd30, 7'd5, 3'd1, 6'd33, 1'b0, 2'b01, 6'd33},
      '{6'd40, 7'd4, 3'd2, 6'd41, 1'b0, 2'b10, 6'd41},
      '{6'd50, 7'd4, 3'd3, 6'd53, 1'b0, 2'b11, 6'd53},
      '{6'd60, 7'd4, 3'd0, 6'd0,  1'b1, 2'b00, 6'd0}
   };

   function automatic int exp_pulses(int a, vec_t v);
      if (a < int'(v.base) || a >= int'(v.base) + int'(v.len)) return 0;
      if (src_mem[a] == 8'hFF) return 0;
      if (v.mode == 3'd1 && a == int'(v.sp)) return 25;
      if (v.mode == 3'd1 && a > int'(v.sp)) return 0;
      if (v.mode == 3'd4 && a == int'(v.sp)) return 25;
      return 1 + a % 3;
   endfunction

   task automatic prep(vec_t v);
      for (int a = 0; a < NMEM; a++) begin
         cells[a]  = 8'hFF;
         pulses[a] = 0;
         need[a]   = 1 + a % 3;
      end
      if (v.mode == 3'd1) need[v.sp] = 26;
      if (v.mode == 3'd4) need[v.sp] = 25;
      weak_addr = (v.mode == 3'd2 || v.mode == 3'd3) ? int'(v.sp) : -1;
      weak_lvl  = (v.mode == 3'd2) ? 2'b10 : 2'b11;
      bad_width = 0; bad_data = 0; bad_level = 0; bad_both = 0;
      hi_seen = 1'b0; lo_before_hi = 1'b0; done_cnt = 0;
   endtask

   task automatic kick(logic [5:0] b, logic [6:0] l);
      @(negedge clk);
      base_addr = b;
      length    = l;
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      for (int a = 0; a < NMEM; a++) begin
         cells[a] = 8'hFF; pulses[a] = 0; need[a] = 1;
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      check(mem_ce_n && mem_oe_n && !vpp_req && vsel == 2'b00 && !done, "R1 reset outputs",
            {mem_ce_n, mem_oe_n, vpp_req, vsel, done}, 6'b110000);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(mem_ce_n && mem_oe_n && !vpp_req && !done, "R1 idle outputs",
            {mem_ce_n, mem_oe_n, vpp_req, done}, 4'b1100);

      for (int i = 0; i < NV; i++) begin
         int pmis;
         int cmis;
         prep(VECS[i]);
         kick(VECS[i].base, VECS[i].len);
         check(done_cnt == 1, "R9 done width", done_cnt, 1);
         check(pass == VECS[i].exp_pass, "R9 pass result", pass, VECS[i].exp_pass);
         if (VECS[i].mode == 3'd1)
            check(fail_phase == 2'b01 && fail_addr == VECS[i].exp_faddr, "R5 cap failure",
                  {fail_phase, fail_addr}, {VECS[i].exp_phase, VECS[i].exp_faddr});
         else
            check(fail_phase == VECS[i].exp_phase && fail_addr == VECS[i].exp_faddr,
                  "R8 fail phase/addr", {fail_phase, fail_addr},
                  {VECS[i].exp_phase, VECS[i].exp_faddr});
         check(bad_width == 0, "R2 pulse width", bad_width, 0);
         check(bad_data == 0, "R2 pulse data", bad_data, 0);
         check(bad_level == 0 && bad_both == 0, "R6 program level", bad_level + bad_both, 0);
         pmis = 0;
         for (int a = 0; a < NMEM; a++) if (pulses[a] != exp_pulses(a, VECS[i])) pmis++;
         check(pmis == 0, "R4 pulse counts", pmis, 0);
         if (VECS[i].mode != 3'd1) begin
            check(!lo_before_hi && hi_seen, "R8 check order", {hi_seen, lo_before_hi}, 2'b10);
            cmis = 0;
            for (int a = int'(VECS[i].base); a < int'(VECS[i].base) + int'(VECS[i].len); a++)
               if (cells[a] != src_mem[a]) cmis++;
            check(cmis == 0, "R3 cells programmed", cmis, 0);
         end
      end

      // R7: erased bytes untouched (addresses 2 and 12 hold 8'hFF)
      prep(VECS[0]);
      kick(6'd0, 7'd6);
      check(pulses[2] == 0 && cells[2] == 8'hFF, "R7 erased skip", pulses[2], 0);
      check(pulses[3] == 1 + 3 % 3, "R3 retry restarts", pulses[3], 1);

      // R9: zero length finishes at once with pass
      prep(VECS[0]);
      kick(6'd5, 7'd0);
      check(pass && done_cnt == 1 && pulses[5] == 0, "R9 zero length",
            {pass, 8'(done_cnt)}, 9'h101);

      // R1: back to idle after a run
      check(mem_ce_n && mem_oe_n && !vpp_req && vsel == 2'b00, "R1 idle after run",
            {mem_ce_n, mem_oe_n, vpp_req, vsel}, 5'b11000);
      finish_run();
   end
endmodule